// File: doc/BRIEF.md
# Cache Maintenance Range Splitter

This block turns one cache maintenance request into an ordered stream of commands for a cache maintenance engine. A request names a byte range with an inclusive start and an exclusive end, and an operation: invalidate, clean, flush (clean then invalidate), or barrier only. The block aligns the range to cache lines and handles partial edge lines for invalidate. It then cuts the aligned span into chunks that stay within a size cap and never cross a page. Each chunk goes out as a range command with an inclusive last-line address. Every request ends with a barrier command.

A write-through override input is sampled with the request. While it is set the cache holds no dirty data, so the block issues no clean range commands. A clean request then becomes a bare barrier, and a flush sends only the invalidate for each chunk.

Requests enter through a valid/ready handshake that accepts only when the block is idle. Commands leave through a valid/ready stream. When the engine holds `cmd_ready` low, the current command stays on the outputs unchanged until it is taken, so the engine can stall the block for any number of cycles. A command is transferred on every rising clock edge where both `cmd_valid` and `cmd_ready` are high.

Top module: `maint_range_splitter`

## Requirements
- R1: After reset `req_ready` is 1, and `busy` and `cmd_valid` are 0.
- R2: A request is taken on a clock edge with `req_valid` and `req_ready` both high. From the next cycle `busy` is 1 and `req_ready` is 0, until the edge that transfers the barrier command. After that edge `busy` is 0 and `req_ready` is 1.
- R3: While `cmd_valid` is 1 and `cmd_ready` is 0, the outputs `cmd_valid`, `cmd_kind`, `cmd_addr` and `cmd_last` hold their values into the next cycle.
- R4: `req_op` is coded 0 invalidate, 1 clean, 2 flush, 3 barrier only. `cmd_kind` is coded 0 single-line clean+invalidate, 1 range clean, 2 range invalidate, 3 barrier. For a line command, `cmd_last` equals `cmd_addr`. For a barrier, both address fields are 0. All line and range addresses are line-aligned.
- R5: A range command covering a chunk [c, n) gives `cmd_addr` = c and `cmd_last` = n − LINE_BYTES. Here n is the least of the span end, c + CHUNK_BYTES, and the next multiple of PAGE_BYTES above c. The next chunk starts at n, and chunks are issued while c is below the span end.
- R6: For invalidate with an unaligned start, a line command for the start's line comes first. The span then begins at the next line boundary.
- R7: For invalidate, if the span start is still below the request end and the end is unaligned, a line command for the end's line follows. The span end is then rounded down to a line.
- R8: For clean and flush, the span runs from the start rounded down to the end rounded up, both to line multiples.
- R9: For flush without override, each chunk gets a range clean, then a range invalidate with the same addresses.
- R10: With `wt_override` set at acceptance, a clean request issues only its barrier, and a flush issues only range invalidates and the barrier.
- R11: Every request ends with exactly one barrier after all its other commands. This holds also when no other command is issued, and for op 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes the request |
| req_op | input | 2 | Operation code (R4) |
| req_start | input | ADDR_W | First byte of range |
| req_end | input | ADDR_W | Byte after the last byte of range |
| wt_override | input | 1 | Write-through override, sampled on acceptance |
| busy | output | 1 | A request is in progress |
| cmd_valid | output | 1 | Command offered to the engine |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_kind | output | 2 | Command code (R4) |
| cmd_addr | output | ADDR_W | First line address |
| cmd_last | output | ADDR_W | Last line address, inclusive |

## Verification
The bench sweeps a small configuration (8-byte lines, 32-byte chunk cap, 64-byte pages) over a grid of start offsets and lengths, for every operation with and without override. This mixes aligned and unaligned edges, and spans that end on the chunk cap, on a page edge or on the request end. The unaligned-start patterns separate the head-line rule from the plain rounding used by clean and flush. Zero-length, reversed and end-of-address-space requests show that a request producing nothing still ends in one barrier, and that rounding up to the top of the address space works. The engine's ready is toggled pseudo-randomly throughout, so every pattern also runs under back-pressure.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  typedef enum logic [1:0] {
    OP_INV   = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2,
    OP_SYNC  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    K_LINE_CI     = 2'd0,
    K_RANGE_CLEAN = 2'd1,
    K_RANGE_INV   = 2'd2,
    K_BARRIER     = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HEAD,
    S_TAIL,
    S_RANGE,
    S_FENCE
  } state_e;

endpackage

// File: rtl/mrs_align.sv
// Request-time alignment: derives the edge-line commands and the span to chunk.
module mrs_align #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  output logic              head_pend,
  output logic [ADDR_W-1:0] head_addr,
  output logic              tail_pend,
  output logic [ADDR_W-1:0] tail_addr,
  output logic [ADDR_W:0]   span_lo,
  output logic [ADDR_W:0]   span_hi
);
  import mrs_pkg::*;

  localparam int AW1 = ADDR_W + 1;
  localparam int LW  = $clog2(LINE_BYTES);
  localparam logic [AW1-1:0] MASK = AW1'(LINE_BYTES - 1);
  localparam logic [AW1-1:0] LINE = AW1'(LINE_BYTES);

  logic            s_unal, e_unal;
  logic [AW1-1:0]  s_down, s_up, e_full, e_down, e_up;

  always_comb begin
    s_unal = (start_addr[LW-1:0] != '0);
    e_unal = (end_addr[LW-1:0] != '0);
    s_down = {1'b0, start_addr} & ~MASK;
    s_up   = s_unal ? s_down + LINE : s_down;
    e_full = {1'b0, end_addr};
    e_down = e_full & ~MASK;
    e_up   = e_unal ? e_down + LINE : e_down;

    head_addr = s_down[ADDR_W-1:0];
    tail_addr = e_down[ADDR_W-1:0];

    if (op == OP_INV) begin
      head_pend = s_unal;
      tail_pend = (s_up < e_full) && e_unal;
      span_lo   = s_up;
      span_hi   = tail_pend ? e_down : e_full;
    end else begin
      head_pend = 1'b0;
      tail_pend = 1'b0;
      span_lo   = s_down;
      span_hi   = e_up;
    end
  end

endmodule

// File: rtl/mrs_chunk.sv
// Chunk bound: least of span end, size cap and next page edge.
module mrs_chunk #(
  parameter int ADDR_W      = 32,
  parameter int CHUNK_BYTES = 1024,
  parameter int PAGE_BYTES  = 4096
) (
  input  logic [ADDR_W:0] cur,
  input  logic [ADDR_W:0] lim,
  output logic [ADDR_W:0] nxt
);
  localparam int AW1 = ADDR_W + 1;
  localparam logic [AW1-1:0] CAP  = AW1'(CHUNK_BYTES);
  localparam logic [AW1-1:0] PMSK = AW1'(PAGE_BYTES - 1);

  logic [AW1-1:0] cap_end, page_end, lo2;

  always_comb begin
    cap_end  = cur + CAP;
    page_end = (cur | PMSK) + AW1'(1);
    lo2      = (cap_end < page_end) ? cap_end : page_end;
    nxt      = (lim < lo2) ? lim : lo2;
  end

  always_comb begin
    if (cur < lim) begin
      AST_CHUNK_ADVANCES: assert (nxt > cur); // R5
    end
  end

endmodule

// File: rtl/maint_range_splitter.sv
module maint_range_splitter #(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 32,
  parameter int CHUNK_BYTES = 1024,
  parameter int PAGE_BYTES  = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  input  logic              wt_override,
  output logic              busy,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [ADDR_W-1:0] cmd_last
);
  import mrs_pkg::*;

  localparam int AW1 = ADDR_W + 1;
  localparam int LW  = $clog2(LINE_BYTES);
  localparam int PW  = $clog2(PAGE_BYTES);
  localparam logic [AW1-1:0] LINE = AW1'(LINE_BYTES);

  state_e            st_q;
  logic [AW1-1:0]    cur_q, lim_q, nxt;
  logic [1:0]        op_q;
  logic              wt_q, phase_q, tail_q;
  logic [ADDR_W-1:0] head_q, tail_addr_q;

  logic              a_head, a_tail;
  logic [ADDR_W-1:0] a_head_addr, a_tail_addr;
  logic [AW1-1:0]    a_lo, a_hi;

  mrs_align #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_align (
    .op(req_op), .start_addr(req_start), .end_addr(req_end),
    .head_pend(a_head), .head_addr(a_head_addr),
    .tail_pend(a_tail), .tail_addr(a_tail_addr),
    .span_lo(a_lo), .span_hi(a_hi)
  );

  mrs_chunk #(.ADDR_W(ADDR_W), .CHUNK_BYTES(CHUNK_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
    .cur(cur_q), .lim(lim_q), .nxt(nxt)
  );

  // Whether a span produces range commands at all for this op / override.
  function automatic logic has_work(input logic [AW1-1:0] lo, input logic [AW1-1:0] hi,
                                    input logic [1:0] op, input logic wt);
    return (lo < hi) && (op != OP_SYNC) && !(op == OP_CLEAN && wt);
  endfunction

  logic work_now, work_new;
  assign work_now = has_work(cur_q, lim_q, op_q, wt_q);
  assign work_new = has_work(a_lo, a_hi, req_op, wt_override);

  assign req_ready = (st_q == S_IDLE);
  assign busy      = (st_q != S_IDLE);
  assign cmd_valid = (st_q != S_IDLE);

  always_comb begin
    cmd_kind = K_BARRIER;
    cmd_addr = '0;
    cmd_last = '0;
    unique case (st_q)
      S_HEAD: begin
        cmd_kind = K_LINE_CI;
        cmd_addr = head_q;
        cmd_last = head_q;
      end
      S_TAIL: begin
        cmd_kind = K_LINE_CI;
        cmd_addr = tail_addr_q;
        cmd_last = tail_addr_q;
      end
      S_RANGE: begin
        if (op_q == OP_INV)        cmd_kind = K_RANGE_INV;
        else if (op_q == OP_CLEAN) cmd_kind = K_RANGE_CLEAN;
        else                       cmd_kind = (phase_q || wt_q) ? K_RANGE_INV : K_RANGE_CLEAN;
        cmd_addr = cur_q[ADDR_W-1:0];
        cmd_last = ADDR_W'(nxt - LINE);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      cur_q       <= '0;
      lim_q       <= '0;
      op_q        <= OP_SYNC;
      wt_q        <= 1'b0;
      phase_q     <= 1'b0;
      tail_q      <= 1'b0;
      head_q      <= '0;
      tail_addr_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_valid) begin
          cur_q       <= a_lo;
          lim_q       <= a_hi;
          op_q        <= req_op;
          wt_q        <= wt_override;
          phase_q     <= 1'b0;
          tail_q      <= a_tail;
          head_q      <= a_head_addr;
          tail_addr_q <= a_tail_addr;
          if (a_head)        st_q <= S_HEAD;
          else if (a_tail)   st_q <= S_TAIL;
          else if (work_new) st_q <= S_RANGE;
          else               st_q <= S_FENCE;
        end
        S_HEAD: if (cmd_ready) begin
          if (tail_q)        st_q <= S_TAIL;
          else if (work_now) st_q <= S_RANGE;
          else               st_q <= S_FENCE;
        end
        S_TAIL: if (cmd_ready) begin
          st_q <= work_now ? S_RANGE : S_FENCE;
        end
        S_RANGE: if (cmd_ready) begin
          if (op_q == OP_FLUSH && !wt_q && !phase_q) begin
            phase_q <= 1'b1;
          end else begin
            phase_q <= 1'b0;
            cur_q   <= nxt;
            st_q    <= (nxt < lim_q) ? S_RANGE : S_FENCE;
          end
        end
        S_FENCE: if (cmd_ready) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_addr) && $stable(cmd_last)); // R3

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready); // R2

  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_addr[LW-1:0] == '0) && (cmd_last[LW-1:0] == '0)); // R4

  AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_kind == K_RANGE_CLEAN || cmd_kind == K_RANGE_INV)
      |-> (cmd_addr >> PW) == (cmd_last >> PW)); // R5

  AST_CHUNK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_kind == K_RANGE_CLEAN || cmd_kind == K_RANGE_INV)
      |-> (cmd_last >= cmd_addr) && ((cmd_last - cmd_addr) <= ADDR_W'(CHUNK_BYTES - LINE_BYTES))); // R5

  AST_FLUSH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_kind == K_RANGE_CLEAN && op_q == OP_FLUSH
      |=> cmd_valid && cmd_kind == K_RANGE_INV && $stable(cmd_addr) && $stable(cmd_last)); // R9

  AST_WT_NO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && wt_q |-> cmd_kind != K_RANGE_CLEAN); // R10

  AST_BARRIER_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_kind == K_BARRIER |=> !busy); // R11

endmodule

// File: tb/test_maint_range_splitter.sv
module test_maint_range_splitter;

  localparam int AW = 8;
  localparam int LB = 8;
  localparam int CB = 32;
  localparam int PB = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_start = '0;
  logic [AW-1:0] req_end = '0;
  logic          wt_override = 1'b0;
  logic          busy;
  logic          cmd_valid;
  logic          cmd_ready = 1'b0;
  logic [1:0]    cmd_kind;
  logic [AW-1:0] cmd_addr;
  logic [AW-1:0] cmd_last;

  always #4 clk = ~clk;

  maint_range_splitter #(.ADDR_W(AW), .LINE_BYTES(LB), .CHUNK_BYTES(CB), .PAGE_BYTES(PB)) i_maint_range_splitter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_start(req_start), .req_end(req_end), .wt_override(wt_override),
    .busy(busy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_last(cmd_last)
  );

  int checks = 0;
  int fails  = 0;
  logic [15:0] lfsr = 16'hACE1;

  int    ek [0:127];
  int    ea [0:127];
  int    el [0:127];
  string et [0:127];
  int    ne;

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic push(input int k, input int a, input int l, input string t);
    ek[ne] = k; ea[ne] = a; el[ne] = l; et[ne] = t;
    ne++;
  endtask

  task automatic chunks(input int cs_in, input int ce, input int op, input int wt);
    int cs = cs_in;
    while (cs < ce) begin
      int re = ce;
      int pb = (cs | (PB - 1)) + 1;
      if (cs + CB < re) re = cs + CB;
      if (pb < re) re = pb;
      if (op == 0) push(2, cs, re - LB, "R5");
      else if (op == 1) push(1, cs, re - LB, "R8");
      else begin
        if (wt == 0) push(1, cs, re - LB, "R9");
        push(2, cs, re - LB, (wt != 0) ? "R10" : "R9");
      end
      cs = re;
    end
  endtask

  task automatic model(input int op, input int s, input int e, input int wt);
    ne = 0;
    if (op == 0) begin
      int cs = s;
      int ce = e;
      if ((cs % LB) != 0) begin
        push(0, cs & ~(LB - 1), cs & ~(LB - 1), "R6");
        cs = (cs | (LB - 1)) + 1;
      end
      if (cs < ce && (ce % LB) != 0) begin
        push(0, ce & ~(LB - 1), ce & ~(LB - 1), "R7");
        ce = ce & ~(LB - 1);
      end
      chunks(cs, ce, op, wt);
    end else if (op == 1 || op == 2) begin
      int cs = s & ~(LB - 1);
      int ce = (e + LB - 1) & ~(LB - 1);
      if (!(op == 1 && wt != 0)) chunks(cs, ce, op, wt);
    end
    push(3, 0, 0, "R11");
  endtask

  task automatic run_req(input int op, input int s, input int e, input int wt);
    int idx = 0;
    bit done = 0;
    int guard = 0;
    bit first = 1;
    model(op, s, e, wt);
    @(negedge clk);
    req_op = 2'(op); req_start = AW'(s); req_end = AW'(e); wt_override = wt[0];
    req_valid = 1'b1;
    check(req_ready == 1'b1, "R2 ready when idle", int'(req_ready), 1);
    @(posedge clk);
    while (!done && guard < 400) begin
      @(negedge clk);
      req_valid = 1'b0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cmd_ready = (lfsr[1:0] != 2'b00);
      if (first) begin
        check(busy && !req_ready, "R2 busy after accept", int'({busy, req_ready}), 2);
        first = 0;
      end
      if (cmd_valid && cmd_ready) begin
        if (idx < ne) begin
          check(int'(cmd_kind) == ek[idx], {et[idx], " kind"}, int'(cmd_kind), ek[idx]);
          check(int'(cmd_addr) == ea[idx] && int'(cmd_last) == el[idx], {et[idx], " addr"},
                int'(cmd_addr) * 1000 + int'(cmd_last), ea[idx] * 1000 + el[idx]);
        end else begin
          check(1'b0, "R11 extra command", int'(cmd_kind), -1);
        end
        if (cmd_kind == 2'd3) done = 1;
        idx++;
      end
      @(posedge clk);
      guard++;
    end
    @(negedge clk);
    cmd_ready = 1'b0;
    check(idx == ne, "R11 command count", idx, ne);
    check(!busy && req_ready, "R2 idle after barrier", int'({busy, req_ready}), 1);
  endtask

  task automatic stall_test();
    logic [1:0]    k0;
    logic [AW-1:0] a0, l0;
    @(negedge clk);
    req_op = 2'd2; req_start = 8'd8; req_end = 8'd72; wt_override = 1'b0; req_valid = 1'b1;
    cmd_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k0 = cmd_kind; a0 = cmd_addr; l0 = cmd_last;
    repeat (5) @(negedge clk);
    check(cmd_valid && cmd_kind == k0 && cmd_addr == a0 && cmd_last == l0, "R3 hold under stall",
          int'(cmd_addr), int'(a0));
    check(int'(cmd_kind) == 1 && int'(cmd_addr) == 8 && int'(cmd_last) == 32, "R9 first flush cmd",
          int'(cmd_last), 32);
    cmd_ready = 1'b1;
    while (!(cmd_valid && cmd_kind == 2'd3)) @(negedge clk);
    @(negedge clk);
    cmd_ready = 1'b0;
    check(!busy, "R11 drained after stall", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !busy && !cmd_valid, "R1 reset state",
          int'({req_ready, busy, cmd_valid}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !busy && !cmd_valid, "R1 after release",
          int'({req_ready, busy, cmd_valid}), 4);

    stall_test();

    for (int op = 0; op < 4; op++)
      for (int wt = 0; wt < 2; wt++)
        for (int s = 0; s < 80; s += 3)
          for (int len = 0; len <= 80; len += 5)
            run_req(op, s, s + len, wt);

    run_req(0, 250, 255, 0);
    run_req(1, 249, 255, 0);
    run_req(2, 192, 255, 0);
    run_req(2, 192, 255, 1);
    run_req(1, 20, 5, 0);
    run_req(0, 20, 5, 0);
    run_req(2, 13, 13, 0);
    run_req(3, 0, 200, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule